// File: doc/BRIEF.md
# Serial Receive Queue with Idle Timeout

This block is the buffer between the receive shift register of a serial port and the CPU. Each time the shift register finishes a character, it raises a one-cycle strobe with the byte. The queue stores the byte in arrival order until the CPU takes it with a read strobe. The oldest byte is always visible on the data output while the queue is not empty. A fixed number of bytes fit, and a character that arrives while the queue is full is dropped and recorded in a sticky overrun flag.

Two interrupt lines tell the CPU when to service the queue. The data interrupt is high while the fill count is at or above a level picked by a 2-bit select. The timeout interrupt covers the case of a short final block that never reaches that level. It rises when bytes sit in the queue and neither a read nor a new byte has touched it for a set number of character times. Character times come from an external tick that pulses once per character period. Both interrupts are masked by a single enable.

Top module: `serial_rx_queue`

## Requirements
- R1: The queue holds up to DEPTH (16) bytes and returns them on `rdData` in arrival order, one byte removed per cycle of `rdStrobe`.
- R2: `trigSel` picks the trigger level: 0 gives 1 byte, 1 gives 4, 2 gives 8 and 3 gives 14. `rxDataIrq` is 1 exactly when `rxIntEn` is 1 and the fill count is at or above that level.
- R3: While DEPTH bytes are held, an incoming character is not stored, and the held bytes are unchanged.
- R4: A character arriving while the queue is full sets `overrun` in the next cycle. The flag stays set until a cycle with `ovrClear` high and no new overrunning character.
- R5: `timeoutIrq` rises after IDLE_CHARS (4) `charTick` pulses with at least one byte held, no accepted write and no accepted read, provided `rxIntEn` is 1. Ticks while the queue is empty count for nothing.
- R6: An accepted read or an accepted write clears `timeoutIrq` in the next cycle and restarts the idle count.
- R7: A read strobe while the queue is empty has no effect: `dataAvail` stays 0, and the next byte written is the next byte read.
- R8: After reset the queue is empty: `dataAvail`, `rdData`, `overrun`, `rxDataIrq` and `timeoutIrq` are all 0.
- R9: With `rxIntEn` at 0, both interrupt outputs stay 0 whatever the fill count or the idle time.
- R10: `rxDataIrq` drops in the cycle after a read takes the fill count below the trigger level.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| charValid | input | 1 | Shift register finished a character this cycle |
| charData | input | 8 | Finished character |
| rdStrobe | input | 1 | CPU removes the oldest byte |
| rdData | output | 8 | Oldest held byte, 0 when empty |
| dataAvail | output | 1 | At least one byte is held |
| ovrClear | input | 1 | CPU status read that clears the overrun flag |
| overrun | output | 1 | Sticky overrun flag |
| trigSel | input | 2 | Trigger level select |
| rxIntEn | input | 1 | Receive interrupt enable |
| charTick | input | 1 | One pulse per character time |
| rxDataIrq | output | 1 | Fill level at or above the trigger level |
| timeoutIrq | output | 1 | Held bytes left idle for the timeout period |

## Verification
The bench builds the block with its defaults: DEPTH 16, WIDTH 8 and IDLE_CHARS 4. At that size it can fill the queue from empty to full and past it for every trigger select, with the enable both on and off, and check the data interrupt at every fill count on the way up and on the way down. The four-character idle window is short enough to step one tick at a time on either side of the threshold. It also shows that empty-queue ticks, reads and writes each restart the count.

// File: rtl/serial_rx_queue_pkg.sv
package serial_rx_queue_pkg;

  // Strobes from control to storage.
  typedef struct packed {
    logic push;
    logic pop;
  } qStrobe_t;

  // Trigger level selection: the code values are part of the interface.
  typedef enum logic [1:0] {
    TRIG_ONE       = 2'd0,
    TRIG_QUARTER   = 2'd1,
    TRIG_HALF      = 2'd2,
    TRIG_NEAR_FULL = 2'd3
  } trigSel_e;

endpackage

// File: rtl/serial_rx_queue_store.sv
module serial_rx_queue_store
  import serial_rx_queue_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  qStrobe_t         strobe,
  input  logic [WIDTH-1:0] wrData,
  output logic [WIDTH-1:0] headData
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PTR_W-1:0] LAST_SLOT = PTR_W'(DEPTH - 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wrPtr;
  logic [PTR_W-1:0] rdPtr;

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == LAST_SLOT) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else begin
      if (strobe.push) wrPtr <= nextPtr(wrPtr);
      if (strobe.pop)  rdPtr <= nextPtr(rdPtr);
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.push) mem[wrPtr] <= wrData;
  end

  assign headData = mem[rdPtr];

endmodule

// File: rtl/serial_rx_queue_ctrl.sv
module serial_rx_queue_ctrl
  import serial_rx_queue_pkg::*;
#(
  parameter int DEPTH      = 16,
  parameter int IDLE_CHARS = 4,
  parameter int CNT_W      = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             charValid,
  input  logic             rdStrobe,
  input  logic             ovrClear,
  input  logic [1:0]       trigSel,
  input  logic             rxIntEn,
  input  logic             charTick,
  output qStrobe_t         strobe,
  output logic [CNT_W-1:0] fillCount,
  output logic             dataAvail,
  output logic             overrun,
  output logic             rxDataIrq,
  output logic             timeoutIrq
);

  localparam int IDLE_W = $clog2(IDLE_CHARS + 1);
  localparam logic [CNT_W-1:0]  FULL_CNT  = CNT_W'(DEPTH);
  localparam logic [IDLE_W-1:0] IDLE_LIM  = IDLE_W'(IDLE_CHARS);

  logic              isFull;
  logic              isEmpty;
  logic [CNT_W-1:0]  trigLevel;
  logic [IDLE_W-1:0] idleCnt;

  assign isFull    = (fillCount == FULL_CNT);
  assign isEmpty   = (fillCount == '0);
  assign dataAvail = !isEmpty;

  assign strobe.push = charValid && !isFull;
  assign strobe.pop  = rdStrobe && !isEmpty;

  always_comb begin
    unique case (trigSel_e'(trigSel))
      TRIG_ONE:       trigLevel = CNT_W'(1);
      TRIG_QUARTER:   trigLevel = CNT_W'(DEPTH / 4);
      TRIG_HALF:      trigLevel = CNT_W'(DEPTH / 2);
      TRIG_NEAR_FULL: trigLevel = CNT_W'(DEPTH - 2);
      default:        trigLevel = CNT_W'(1);
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fillCount <= '0;
    end else begin
      unique case ({strobe.push, strobe.pop})
        2'b10:   fillCount <= fillCount + 1'b1;
        2'b01:   fillCount <= fillCount - 1'b1;
        default: fillCount <= fillCount;
      endcase
    end
  end

  // Idle timer in character times; any accepted access restarts it.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      idleCnt <= '0;
    end else if (strobe.push || strobe.pop || isEmpty) begin
      idleCnt <= '0;
    end else if (charTick && idleCnt != IDLE_LIM) begin
      idleCnt <= idleCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      overrun <= 1'b0;
    end else if (charValid && isFull) begin
      overrun <= 1'b1;
    end else if (ovrClear) begin
      overrun <= 1'b0;
    end
  end

  assign rxDataIrq  = rxIntEn && (fillCount >= trigLevel);
  assign timeoutIrq = rxIntEn && !isEmpty && (idleCnt == IDLE_LIM);

endmodule

// File: rtl/serial_rx_queue.sv
module serial_rx_queue
  import serial_rx_queue_pkg::*;
#(
  parameter int DEPTH      = 16,
  parameter int WIDTH      = 8,
  parameter int IDLE_CHARS = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             charValid,
  input  logic [WIDTH-1:0] charData,
  input  logic             rdStrobe,
  output logic [WIDTH-1:0] rdData,
  output logic             dataAvail,
  input  logic             ovrClear,
  output logic             overrun,
  input  logic [1:0]       trigSel,
  input  logic             rxIntEn,
  input  logic             charTick,
  output logic             rxDataIrq,
  output logic             timeoutIrq
);

  localparam int CNT_W = $clog2(DEPTH + 1);

  qStrobe_t         strobe;
  logic [CNT_W-1:0] fillCount;
  logic [WIDTH-1:0] headData;

  serial_rx_queue_ctrl #(
    .DEPTH(DEPTH), .IDLE_CHARS(IDLE_CHARS), .CNT_W(CNT_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .charValid(charValid), .rdStrobe(rdStrobe),
    .ovrClear(ovrClear), .trigSel(trigSel), .rxIntEn(rxIntEn),
    .charTick(charTick), .strobe(strobe), .fillCount(fillCount),
    .dataAvail(dataAvail), .overrun(overrun), .rxDataIrq(rxDataIrq),
    .timeoutIrq(timeoutIrq)
  );

  serial_rx_queue_store #(
    .DEPTH(DEPTH), .WIDTH(WIDTH)
  ) u_store (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrData(charData),
    .headData(headData)
  );

  assign rdData = dataAvail ? headData : '0;

endmodule

// File: rtl/serial_rx_queue_chk.sv
module serial_rx_queue_chk #(
  parameter int DEPTH = 16,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rstN,
  input logic             charValid,
  input logic             rdStrobe,
  input logic             ovrClear,
  input logic             rxIntEn,
  input logic [CNT_W-1:0] fillCount,
  input logic             dataAvail,
  input logic             overrun,
  input logic             rxDataIrq,
  input logic             timeoutIrq
);

  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  AST_FILL_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    fillCount <= FULL_CNT); // R1

  AST_PUSH_GROWS: assert property (@(posedge clk) disable iff (!rstN)
    (charValid && !rdStrobe && fillCount != FULL_CNT)
      |=> fillCount == $past(fillCount) + 1'b1); // R1

  AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (fillCount == FULL_CNT && charValid && !rdStrobe) |=> fillCount == FULL_CNT); // R3

  AST_OVERRUN_SET: assert property (@(posedge clk) disable iff (!rstN)
    (fillCount == FULL_CNT && charValid) |=> overrun); // R4

  AST_OVERRUN_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (ovrClear && !charValid) |=> !overrun); // R4

  AST_TIMEOUT_READ_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (rdStrobe && dataAvail) |=> !timeoutIrq); // R6

  AST_TIMEOUT_WRITE_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (charValid && fillCount != FULL_CNT) |=> !timeoutIrq); // R6

  AST_EMPTY_READ_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (rdStrobe && !dataAvail && !charValid) |=> !dataAvail); // R7

  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rstN)
    !rxIntEn |-> (!rxDataIrq && !timeoutIrq)); // R9

endmodule

bind serial_rx_queue serial_rx_queue_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .charValid(charValid), .rdStrobe(rdStrobe),
  .ovrClear(ovrClear), .rxIntEn(rxIntEn), .fillCount(fillCount),
  .dataAvail(dataAvail), .overrun(overrun), .rxDataIrq(rxDataIrq),
  .timeoutIrq(timeoutIrq)
);

// File: tb/serial_rx_queue_bench.sv
module serial_rx_queue_bench;

  localparam int DEPTH = 16;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       charValid = 1'b0;
  logic [7:0] charData = '0;
  logic       rdStrobe = 1'b0;
  logic [7:0] rdData;
  logic       dataAvail;
  logic       ovrClear = 1'b0;
  logic       overrun;
  logic [1:0] trigSel = 2'd0;
  logic       rxIntEn = 1'b0;
  logic       charTick = 1'b0;
  logic       rxDataIrq;
  logic       timeoutIrq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk; // 250 MHz

  serial_rx_queue u_serial_rx_queue (
    .clk(clk), .rstN(rstN), .charValid(charValid), .charData(charData),
    .rdStrobe(rdStrobe), .rdData(rdData), .dataAvail(dataAvail),
    .ovrClear(ovrClear), .overrun(overrun), .trigSel(trigSel),
    .rxIntEn(rxIntEn), .charTick(charTick), .rxDataIrq(rxDataIrq),
    .timeoutIrq(timeoutIrq)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int trigOf(input int s);
    return (s == 0) ? 1 : (s == 1) ? 4 : (s == 2) ? 8 : 14;
  endfunction

  task automatic pushByte(input logic [7:0] b);
    @(negedge clk); charValid = 1'b1; charData = b;
    @(negedge clk); charValid = 1'b0; #1;
  endtask

  task automatic popByte();
    @(negedge clk); rdStrobe = 1'b1;
    @(negedge clk); rdStrobe = 1'b0; #1;
  endtask

  task automatic tick();
    @(negedge clk); charTick = 1'b1;
    @(negedge clk); charTick = 1'b0; #1;
  endtask

  task automatic clearOvr();
    @(negedge clk); ovrClear = 1'b1;
    @(negedge clk); ovrClear = 1'b0; #1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    // R8: reset state
    chk(dataAvail == 0 && rdData == 0, "R8 empty after reset", dataAvail, 0);
    chk(overrun == 0 && rxDataIrq == 0 && timeoutIrq == 0, "R8 flags after reset",
        {overrun, rxDataIrq, timeoutIrq}, 0);
    @(negedge clk); rstN = 1'b1; #1;

    // R7: read while empty is ignored
    popByte();
    chk(dataAvail == 0, "R7 empty read keeps empty", dataAvail, 0);
    pushByte(8'h5A);
    chk(rdData == 8'h5A, "R7 next byte after empty read", rdData, 8'h5A);
    popByte();
    chk(dataAvail == 0, "R7 drained", dataAvail, 0);

    // Sweep over enable and trigger select: fill, overflow, drain.
    for (int en = 1; en >= 0; en--) begin
      for (int s = 0; s < 4; s++) begin
        rxIntEn = en[0]; trigSel = s[1:0];
        for (int i = 0; i < DEPTH; i++) begin
          pushByte(8'((s * 37 + i * 11 + en * 5) & 8'hFF));
          chk(rxDataIrq == (en == 1 && i + 1 >= trigOf(s)),
              (en == 1) ? "R2 data irq on fill" : "R9 data irq masked",
              rxDataIrq, (en == 1 && i + 1 >= trigOf(s)));
        end
        chk(overrun == 0, "R4 no overrun at exactly full", overrun, 0);
        pushByte(8'hEE);
        chk(overrun == 1, "R4 overrun set on full write", overrun, 1);
        pushByte(8'hEF);
        clearOvr();
        chk(overrun == 0, "R4 overrun cleared by status read", overrun, 0);
        for (int i = 0; i < DEPTH; i++) begin
          chk(rdData == 8'((s * 37 + i * 11 + en * 5) & 8'hFF),
              (i == 0) ? "R3 full keeps contents" : "R1 order on drain",
              rdData, (s * 37 + i * 11 + en * 5) & 8'hFF);
          popByte();
          chk(rxDataIrq == (en == 1 && DEPTH - 1 - i >= trigOf(s)),
              "R10 data irq after read", rxDataIrq,
              (en == 1 && DEPTH - 1 - i >= trigOf(s)));
        end
        chk(dataAvail == 0, "R3 overrunning bytes not stored", dataAvail, 0);
      end
    end

    // Timeout behaviour, trigger 14 so the data interrupt stays low.
    rxIntEn = 1'b1; trigSel = 2'd3;
    for (int k = 0; k < 6; k++) tick();
    pushByte(8'h11);
    for (int k = 0; k < 3; k++) begin
      tick();
      chk(timeoutIrq == 0, "R5 empty ticks not counted", timeoutIrq, 0);
    end
    pushByte(8'h22);
    for (int k = 1; k <= 4; k++) begin
      tick();
      chk(timeoutIrq == (k == 4), "R5 timeout after four ticks", timeoutIrq, (k == 4));
    end
    chk(rxDataIrq == 0, "R2 below trigger no data irq", rxDataIrq, 0);
    popByte();
    chk(timeoutIrq == 0 && rdData == 8'h22, "R6 read clears timeout", timeoutIrq, 0);
    for (int k = 1; k <= 4; k++) begin
      tick();
      chk(timeoutIrq == (k == 4), "R6 idle count restarted after read", timeoutIrq, (k == 4));
    end
    pushByte(8'h33);
    chk(timeoutIrq == 0, "R6 write clears timeout", timeoutIrq, 0);
    rxIntEn = 1'b0;
    for (int k = 0; k < 5; k++) tick();
    chk(timeoutIrq == 0, "R9 timeout masked", timeoutIrq, 0);
    rxIntEn = 1'b1; #1;
    chk(timeoutIrq == 1, "R5 idle time kept while masked", timeoutIrq, 1);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule